// File: doc/BRIEF.md
# Quad-Channel Double-Buffered DAC Register Bank

This block holds the digital state behind a four-channel converter. It takes command words that a serial front end has already assembled and passes them in with a one-cycle valid strobe. Each word picks one channel and carries three things for it: a 12-bit code, a power-down request and a settling-speed choice. Every channel has two code registers. The staging register takes each accepted code. The output register drives the converter.

The active-low load input controls when staged codes move to the outputs. While the load input is high, outputs hold their values, so software can stage new codes on several channels. Pulling the load input low then moves all staged codes to the outputs in the same cycle. With the load input tied low, a write goes straight to the addressed output.

A second active-low input powers down every channel at once, whatever the per-channel flags say. Neither kind of power-down touches the code registers. When power-down is released, each channel resumes with the code it held before.

Top module: `dacbank_regs`

## Requirements
- R1: After reset, every output code is 0, every per-channel power-down flag is 0 (active) and every speed flag is 0 (slow).
- R2: Bits 15:14 of the command word choose the channel: 00 is channel 0, 01 is channel 1, 10 is channel 2 and 11 is channel 3. A write changes no other channel.
- R3: While the load input is high, an accepted word updates only the staging code of its channel. No output code changes.
- R4: An accepted word that arrives while the load input is low appears on its channel's output code one clock after the strobe. Bits 11:0 of the word carry the code.
- R5: In every clock cycle in which the load input is low, every output code takes its channel's staging code, and all channels do so in the same cycle.
- R6: Bit 13 of an accepted word sets the addressed channel's power-down flag (1 = powered down, 0 = active). The flag is visible one clock after the strobe, whatever the load input does.
- R7: Bit 12 of an accepted word sets the addressed channel's speed output (1 = fast settling, 0 = slow). The output is visible one clock after the strobe, whatever the load input does.
- R8: While the global power-down input is low, every channel's power-down output is 1.
- R9: Power-down changes no code register. After the global power-down is released, each channel's power-down output returns to its own flag, and each output code is the same as before.
- R10: A word presented while the valid strobe is low changes no code and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Strobe that accepts `cmd_word` on this clock |
| cmd_word | input | 16 | Command word: channel select, power-down bit, speed bit, code |
| load_n | input | 1 | Active-low transfer of staging codes to output codes |
| pwrdn_n | input | 1 | Active-low power-down of all channels |
| dac_code | output | 48 | Output codes; channel i is in bits i*12+11 : i*12 |
| dac_pd | output | 4 | Power-down output for each channel |
| dac_fast | output | 4 | Fast-settling select for each channel |

## Verification
The bench stages codes on three channels with the load input high, then confirms that no output moved. A design that copied staged codes too early would fail here. It then releases the load for a single cycle with no write pending, which exposes a design that transfers only the addressed channel or needs an edge rather than a level. Flags are written with the load input held high, which catches flags that were wrongly double-buffered like the codes. Finally, the bench enters and leaves global power-down, and presents invalid words under a following load pulse. This shows any design that clears codes on power-down or lets an unstrobed word leak into the staging registers.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
   localparam int DEF_NUM_CH = 4;
   localparam int DEF_CODE_W = 12;

   typedef enum logic {
      SETTLE_SLOW = 1'b0,
      SETTLE_FAST = 1'b1
   } settle_e;
endpackage

// File: rtl/dacbank_decode.sv
module dacbank_decode
   import dacbank_pkg::*;
#(
   parameter int NUM_CH = DEF_NUM_CH,
   parameter int CODE_W = DEF_CODE_W,
   localparam int ADDR_W = $clog2(NUM_CH),
   localparam int WORD_W = ADDR_W + 2 + CODE_W
) (
   input  logic              cmd_valid,
   input  logic [WORD_W-1:0] cmd_word,
   output logic [NUM_CH-1:0] wr_en,
   output logic [CODE_W-1:0] wr_code,
   output logic              wr_pd,
   output settle_e           wr_speed
);
   localparam int SPD_BIT = CODE_W;
   localparam int PD_BIT  = CODE_W + 1;

   logic [ADDR_W-1:0] sel;

   assign sel      = cmd_word[WORD_W-1 -: ADDR_W];
   assign wr_code  = cmd_word[CODE_W-1:0];
   assign wr_pd    = cmd_word[PD_BIT];
   assign wr_speed = settle_e'(cmd_word[SPD_BIT]);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
      assign wr_en[i] = cmd_valid && (sel == ADDR_W'(i));
   end
endmodule

// File: rtl/dacbank_chan.sv
module dacbank_chan
   import dacbank_pkg::*;
#(
   parameter int CODE_W    = DEF_CODE_W,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] wr_code,
   input  logic              wr_pd,
   input  settle_e           wr_speed,
   input  logic              load_n,
   output logic [CODE_W-1:0] out_code,
   output logic              pd_flag,
   output logic              fast_flag
);
   logic [CODE_W-1:0] stage_q, stage_d, out_q, out_d;
   logic              pd_q, pd_d, fast_q, fast_d;

   always_comb begin
      stage_d = wr_en ? wr_code : stage_q;
      out_d   = load_n ? out_q : stage_d;
      pd_d    = wr_en ? wr_pd : pd_q;
      fast_d  = wr_en ? (wr_speed == SETTLE_FAST) : fast_q;
   end

   if (ASYNC_RST) begin : g_arst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q <= '0;
            out_q   <= '0;
            pd_q    <= 1'b0;
            fast_q  <= 1'b0;
         end else begin
            stage_q <= stage_d;
            out_q   <= out_d;
            pd_q    <= pd_d;
            fast_q  <= fast_d;
         end
      end
   end else begin : g_srst
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stage_q <= '0;
            out_q   <= '0;
            pd_q    <= 1'b0;
            fast_q  <= 1'b0;
         end else begin
            stage_q <= stage_d;
            out_q   <= out_d;
            pd_q    <= pd_d;
            fast_q  <= fast_d;
         end
      end
   end

   assign out_code  = out_q;
   assign pd_flag   = pd_q;
   assign fast_flag = fast_q;

   AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      load_n |=> $stable(out_code)); // R3
   AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !load_n) |=> (out_code == $past(wr_code))); // R4
   AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !load_n) |=> (out_code == $past(stage_q))); // R5
   AST_PD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (pd_flag == $past(wr_pd))); // R6
   AST_SPEED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (fast_flag == $past(wr_speed == SETTLE_FAST))); // R7
   AST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(pd_flag) && $stable(fast_flag) && $stable(stage_q))); // R10
endmodule

// File: rtl/dacbank_regs.sv
module dacbank_regs
   import dacbank_pkg::*;
#(
   parameter int NUM_CH    = DEF_NUM_CH,
   parameter int CODE_W    = DEF_CODE_W,
   parameter bit ASYNC_RST = 1'b1,
   localparam int ADDR_W = $clog2(NUM_CH),
   localparam int WORD_W = ADDR_W + 2 + CODE_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cmd_valid,
   input  logic [WORD_W-1:0]        cmd_word,
   input  logic                     load_n,
   input  logic                     pwrdn_n,
   output logic [NUM_CH*CODE_W-1:0] dac_code,
   output logic [NUM_CH-1:0]        dac_pd,
   output logic [NUM_CH-1:0]        dac_fast
);
   if (NUM_CH < 2 || NUM_CH != (1 << ADDR_W)) begin : g_bad_ch
      $error("dacbank_regs: NUM_CH must be a power of two, at least 2");
   end
   if (CODE_W < 1) begin : g_bad_code
      $error("dacbank_regs: CODE_W must be positive");
   end

   logic [NUM_CH-1:0] wr_en;
   logic [CODE_W-1:0] wr_code;
   logic              wr_pd;
   settle_e           wr_speed;
   logic [NUM_CH-1:0] pd_flag;

   dacbank_decode #(
      .NUM_CH (NUM_CH),
      .CODE_W (CODE_W)
   ) i_decode (
      .cmd_valid (cmd_valid),
      .cmd_word  (cmd_word),
      .wr_en     (wr_en),
      .wr_code   (wr_code),
      .wr_pd     (wr_pd),
      .wr_speed  (wr_speed)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      dacbank_chan #(
         .CODE_W    (CODE_W),
         .ASYNC_RST (ASYNC_RST)
      ) i_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_en[i]),
         .wr_code   (wr_code),
         .wr_pd     (wr_pd),
         .wr_speed  (wr_speed),
         .load_n    (load_n),
         .out_code  (dac_code[i*CODE_W +: CODE_W]),
         .pd_flag   (pd_flag[i]),
         .fast_flag (dac_fast[i])
      );
      assign dac_pd[i] = pd_flag[i] | ~pwrdn_n;
   end

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_en)); // R2
   AST_IDLE_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> (wr_en == '0)); // R10
   AST_GLOBAL_PD: assert property (@(posedge clk) disable iff (!rst_n)
      !pwrdn_n |-> (dac_pd == '1)); // R8
   AST_PD_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pwrdn_n) && load_n) |-> $stable(dac_code)); // R9
endmodule

// File: tb/test_dacbank_regs.sv
module test_dacbank_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [15:0] cmd_word = '0;
   logic        load_n = 1'b1;
   logic        pwrdn_n = 1'b1;
   logic [47:0] dac_code;
   logic [3:0]  dac_pd;
   logic [3:0]  dac_fast;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   dacbank_regs i_dacbank_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_word  (cmd_word),
      .load_n    (load_n),
      .pwrdn_n   (pwrdn_n),
      .dac_code  (dac_code),
      .dac_pd    (dac_pd),
      .dac_fast  (dac_fast)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] code_of(input int ch);
      return dac_code[ch*12 +: 12];
   endfunction

   task automatic check_codes(input string req, input logic [11:0] c0, input logic [11:0] c1,
                              input logic [11:0] c2, input logic [11:0] c3);
      check({req, " ch0"}, 32'(code_of(0)), 32'(c0));
      check({req, " ch1"}, 32'(code_of(1)), 32'(c1));
      check({req, " ch2"}, 32'(code_of(2)), 32'(c2));
      check({req, " ch3"}, 32'(code_of(3)), 32'(c3));
   endtask

   // one accepted word; returns at the falling edge after the capturing edge
   task automatic send(input logic [15:0] w, input logic ld_n);
      cmd_word  = w;
      cmd_valid = 1'b1;
      load_n    = ld_n;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      load_n    = 1'b1;
   endtask

   task automatic pulse_load();
      load_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      load_n = 1'b1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_codes("R1 codes", 12'h000, 12'h000, 12'h000, 12'h000);
      check("R1 pd", 32'(dac_pd), 32'h0);
      check("R1 fast", 32'(dac_fast), 32'h0);
   endtask

   task automatic t_decode();
      send(16'h8ABC, 1'b0); // select 10 -> channel 2
      check_codes("R2 select", 12'h000, 12'h000, 12'hABC, 12'h000);
   endtask

   task automatic t_staged();
      send(16'h0111, 1'b1);
      send(16'h4222, 1'b1);
      send(16'hC333, 1'b1);
      check_codes("R3 held", 12'h000, 12'h000, 12'hABC, 12'h000);
      pulse_load();
      check_codes("R5 simultaneous", 12'h111, 12'h222, 12'hABC, 12'h333);
   endtask

   task automatic t_through();
      send(16'h45A5, 1'b0);
      check_codes("R4 through", 12'h111, 12'h5A5, 12'hABC, 12'h333);
   endtask

   task automatic t_flags();
      send(16'hFFFF, 1'b1); // ch3 pd=1 fast=1 code FFF, load high
      check("R6 pd immediate", 32'(dac_pd), 32'h8);
      check("R7 fast immediate", 32'(dac_fast), 32'h8);
      check("R3 flags word code held", 32'(code_of(3)), 32'h333);
      send(16'h1111, 1'b1); // ch0 pd=0 fast=1
      check("R7 fast ch0", 32'(dac_fast), 32'h9);
      check("R6 pd ch0 active", 32'(dac_pd), 32'h8);
   endtask

   task automatic t_global_pd();
      pwrdn_n = 1'b0;
      @(negedge clk);
      check("R8 all down", 32'(dac_pd), 32'hF);
      repeat (2) @(negedge clk);
      pwrdn_n = 1'b1;
      @(negedge clk);
      check("R9 flags back", 32'(dac_pd), 32'h8);
      check_codes("R9 codes kept", 12'h111, 12'h5A5, 12'hABC, 12'h333);
   endtask

   task automatic t_invalid();
      cmd_word  = 16'h7000; // ch1 pd=1 fast=1 code 000, strobe low
      cmd_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R10 pd unchanged", 32'(dac_pd), 32'h8);
      check("R10 fast unchanged", 32'(dac_fast), 32'h9);
      pulse_load();
      check_codes("R10 stage untouched", 12'h111, 12'h5A5, 12'hABC, 12'hFFF);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_decode();
      t_staged();
      t_through();
      t_flags();
      t_global_pd();
      t_invalid();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule